// File: doc/BRIEF.md
# Keyed configuration port controller

This block implements a small indexed register space reached through two adjacent byte-wide I/O ports, an index port and the data port just above it. After reset the space is sealed. A fixed four-byte key written to the index port opens it. While it is open, a byte written to the index port selects a register, and the data port then reads or writes that register. A write of the exit command through the exit register seals the space again.

The register space has two levels. Global registers hold a logical-device selector, a two-byte chip identifier and a revision byte. Behind the selector sit banks of per-device registers. Each bank has an enable register and a two-byte base address. Only the bank whose device number matches the selector can be seen. The enable bit and base address of every bank are also driven as outputs, so that the devices they configure can use them directly.

The host side uses single-cycle read and write strobes with an 8-bit data bus. Read data is registered, and it holds its value until the next read of either port.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the space is sealed, `io_rdata` is 0x00, the device selector is 0x00, and every device enable bit and base address is zero.
- R2: While the space is sealed, reads of either port return 0xFF, and data-port writes change no register and no output.
- R3: Writing the bytes 0x87, 0x01, 0x55, 0x55 in that order to the index port opens the space. The selected index is then 0x00, and index-port reads return the selected index.
- R4: A byte that breaks the key sequence sends the matcher back to the start. If that byte is 0x87, it is counted as the first key byte.
- R5: A data-port write of 0x02 while index 0x02 is selected seals the space and clears the index. Any other value written there leaves the space open.
- R6: Index 0x20 reads the high byte and index 0x21 the low byte of the chip identifier. Index 0x22 reads the revision, with its upper four bits forced to zero. Writes to these three indices are discarded.
- R7: Index 0x07 is a read/write device selector. Device numbers 0x07, 0x09 and 0x0A select banks 0, 1 and 2.
- R8: In the selected bank, index 0x30 stores only bit 0 of the written byte as the enable bit, reads back as 0x00 or 0x01, and drives `dev_active[bank]`.
- R9: In the selected bank, index 0x60 holds the high byte and index 0x61 the low byte of the base address. The address drives `dev_base[bank*16 +: 16]`.
- R10: Reads of an index that is not implemented, or of a per-device index while the selector matches no bank, return 0x00. Writes to them are discarded.
- R11: Read data appears on `io_rdata` in the cycle after the read strobe and holds until the next port read. When read and write strobes on the data port fall in the same cycle, the read returns the value from before the write.
- R12: Strobes at any address other than the two ports change no state and leave `io_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | input | ADDR_W | I/O address of the access |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| cfg_unlocked | output | 1 | High while the register space is open |
| dev_active | output | NUM_DEV | Enable bit of each device bank |
| dev_base | output | 16*NUM_DEV | Base address of each device bank, bank 0 in the low bits |

## Verification
A data-port read and a data-port write can land in the same cycle. The read must return the register contents from before the write, and the write must still take effect. This applies to the enable and base registers, to the device selector itself, and to the exit command, whose read-back happens in the same cycle that seals the space. The bench issues both strobes together on purpose, in directed cases and in the random phase. It compares the returned byte with its model's state from before the write, and it then checks the outputs and later reads against the model's state after the write.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam int KEY_LEN = 4;

  localparam logic [7:0] IX_EXIT    = 8'h02;
  localparam logic [7:0] IX_LDN     = 8'h07;
  localparam logic [7:0] IX_ID_HI   = 8'h20;
  localparam logic [7:0] IX_ID_LO   = 8'h21;
  localparam logic [7:0] IX_REV     = 8'h22;
  localparam logic [7:0] IX_ACT     = 8'h30;
  localparam logic [7:0] IX_BASE_HI = 8'h60;
  localparam logic [7:0] IX_BASE_LO = 8'h61;

  localparam logic [7:0] EXIT_CMD   = 8'h02;
  localparam logic [7:0] SEALED_RD  = 8'hFF;

  // byte expected at position pos of the unlock key
  function automatic logic [7:0] key_at(input int pos);
    case (pos)
      0:       key_at = 8'h87;
      1:       key_at = 8'h01;
      default: key_at = 8'h55;
    endcase
  endfunction

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/cfg_key_match.sv
module cfg_key_match
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  output logic       key_hit
);

  localparam int CW = $clog2(KEY_LEN);
  localparam logic [CW-1:0] LAST = CW'(KEY_LEN - 1);

  logic [CW-1:0] pos_q;
  logic [CW-1:0] pos_d;

  always_comb begin
    pos_d   = pos_q;
    key_hit = 1'b0;
    if (key_wr) begin
      if (key_byte == key_at(int'(pos_q))) begin
        if (pos_q == LAST) begin
          key_hit = 1'b1;
          pos_d   = '0;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end else if (key_byte == key_at(0)) begin
        pos_d = CW'(1);
      end else begin
        pos_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (key_wr) begin
      pos_q <= pos_d;
    end
  end

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_port_pkg::*;
#(
  parameter logic [7:0] DEV_LDN = 8'h07
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  idx,
  input  logic [7:0]  ldn_sel,
  input  logic [7:0]  wdata,
  output logic        active,
  output logic [15:0] base,
  output logic [7:0]  rd_val
);

  logic        sel;
  logic        act_q, act_d;
  logic [15:0] base_q, base_d;
  logic        upd;

  assign sel = (ldn_sel == DEV_LDN);
  assign upd = wr_en && sel;

  always_comb begin
    act_d  = act_q;
    base_d = base_q;
    if (upd) begin
      case (idx)
        IX_ACT:     act_d         = wdata[0];
        IX_BASE_HI: base_d[15:8]  = wdata;
        IX_BASE_LO: base_d[7:0]   = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
    end else if (upd) begin
      act_q  <= act_d;
      base_q <= base_d;
    end
  end

  always_comb begin
    rd_val = 8'h00;
    if (sel) begin
      case (idx)
        IX_ACT:     rd_val = {7'b0, act_q};
        IX_BASE_HI: rd_val = base_q[15:8];
        IX_BASE_LO: rd_val = base_q[7:0];
        default:    rd_val = 8'h00;
      endcase
    end
  end

  assign active = act_q;
  assign base   = base_q;

endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int                  ADDR_W     = 16,
  parameter logic [ADDR_W-1:0]   INDEX_ADDR = 16'h002E,
  parameter logic [15:0]         CHIP_ID    = 16'h8712,
  parameter logic [7:0]          CHIP_REV   = 8'h18,
  parameter int                  NUM_DEV    = 3,
  parameter logic [8*NUM_DEV-1:0] DEV_LDNS  = 24'h0A_09_07
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       io_addr,
  input  logic                    io_wr,
  input  logic                    io_rd,
  input  logic [7:0]              io_wdata,
  output logic [7:0]              io_rdata,
  output logic                    cfg_unlocked,
  output logic [NUM_DEV-1:0]      dev_active,
  output logic [16*NUM_DEV-1:0]   dev_base
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = INDEX_ADDR + ADDR_W'(1);

  logic       rst_n_int;
  logic       is_idx, is_dat;
  logic       key_wr, key_hit, dat_wr;
  logic       unl_q, unl_d;
  logic [7:0] idx_q, idx_d;
  logic [7:0] ldn_q, ldn_d;
  logic [7:0] rdata_q, rdata_d;
  logic [7:0] glob_val, reg_val;
  logic [7:0] bank_val [NUM_DEV];

  cfg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign is_idx = (io_addr == INDEX_ADDR);
  assign is_dat = (io_addr == DATA_ADDR);
  assign key_wr = io_wr && is_idx && !unl_q;
  assign dat_wr = io_wr && is_dat && unl_q;

  cfg_key_match u_key (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .key_wr   (key_wr),
    .key_byte (io_wdata),
    .key_hit  (key_hit)
  );

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
    cfg_dev_bank #(.DEV_LDN(DEV_LDNS[g*8 +: 8])) u_bank (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .wr_en   (dat_wr),
      .idx     (idx_q),
      .ldn_sel (ldn_q),
      .wdata   (io_wdata),
      .active  (dev_active[g]),
      .base    (dev_base[g*16 +: 16]),
      .rd_val  (bank_val[g])
    );
  end

  // global register read mux
  always_comb begin
    case (idx_q)
      IX_LDN:   glob_val = ldn_q;
      IX_ID_HI: glob_val = CHIP_ID[15:8];
      IX_ID_LO: glob_val = CHIP_ID[7:0];
      IX_REV:   glob_val = {4'h0, CHIP_REV[3:0]};
      default:  glob_val = 8'h00;
    endcase
  end

  // banks return zero unless selected and addressed, so OR-merge them
  always_comb begin
    reg_val = glob_val;
    for (int i = 0; i < NUM_DEV; i++) begin
      reg_val = reg_val | bank_val[i];
    end
  end

  always_comb begin
    unl_d   = unl_q;
    idx_d   = idx_q;
    ldn_d   = ldn_q;
    rdata_d = rdata_q;
    if (key_hit) begin
      unl_d = 1'b1;
    end
    if (io_wr && is_idx && unl_q) begin
      idx_d = io_wdata;
    end
    if (dat_wr && idx_q == IX_LDN) begin
      ldn_d = io_wdata;
    end
    if (dat_wr && idx_q == IX_EXIT && io_wdata == EXIT_CMD) begin
      unl_d = 1'b0;
      idx_d = 8'h00;
    end
    if (io_rd && is_idx) begin
      rdata_d = unl_q ? idx_q : SEALED_RD;
    end else if (io_rd && is_dat) begin
      rdata_d = unl_q ? reg_val : SEALED_RD;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      unl_q   <= 1'b0;
      idx_q   <= 8'h00;
      ldn_q   <= 8'h00;
      rdata_q <= 8'h00;
    end else begin
      unl_q   <= unl_d;
      idx_q   <= idx_d;
      ldn_q   <= ldn_d;
      rdata_q <= rdata_d;
    end
  end

  assign io_rdata     = rdata_q;
  assign cfg_unlocked = unl_q;

endmodule

// File: rtl/cfg_port_ctrl_chk.sv
module cfg_port_ctrl_chk #(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 16'h002E,
  parameter int                NUM_DEV    = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     io_addr,
  input logic                  io_wr,
  input logic                  io_rd,
  input logic [7:0]            io_wdata,
  input logic [7:0]            io_rdata,
  input logic                  cfg_unlocked,
  input logic [NUM_DEV-1:0]    dev_active,
  input logic [16*NUM_DEV-1:0] dev_base,
  input logic [7:0]            idx
);

  logic at_idx, at_dat;
  assign at_idx = (io_addr == INDEX_ADDR);
  assign at_dat = (io_addr == INDEX_ADDR + ADDR_W'(1));

  a_r2_sealed_read: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && (at_idx || at_dat) && !cfg_unlocked) |=> (io_rdata == 8'hFF));

  a_r2_sealed_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_unlocked |=> ($stable(dev_active) && $stable(dev_base)));

  a_r3_open_on_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_unlocked) |-> $past(io_wr && at_idx && io_wdata == 8'h55));

  a_r5_seal_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_unlocked) |-> $past(io_wr && at_dat && io_wdata == 8'h02 && idx == 8'h02));

  a_r6_rev_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && at_dat && cfg_unlocked && idx == 8'h22) |=> (io_rdata[7:4] == 4'h0));

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && (at_idx || at_dat)) |=> $stable(io_rdata));

endmodule

bind cfg_port_ctrl cfg_port_ctrl_chk #(
  .ADDR_W     (ADDR_W),
  .INDEX_ADDR (INDEX_ADDR),
  .NUM_DEV    (NUM_DEV)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_int),
  .io_addr      (io_addr),
  .io_wr        (io_wr),
  .io_rd        (io_rd),
  .io_wdata     (io_wdata),
  .io_rdata     (io_rdata),
  .cfg_unlocked (cfg_unlocked),
  .dev_active   (dev_active),
  .dev_base     (dev_base),
  .idx          (idx_q)
);

// File: tb/cfg_port_ctrl_tb.sv
module cfg_port_ctrl_tb;

  localparam int          ADDR_W = 16;
  localparam logic [15:0] IXA    = 16'h002E;
  localparam logic [15:0] DTA    = 16'h002F;
  localparam int          ND     = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] io_addr;
  logic              io_wr, io_rd;
  logic [7:0]        io_wdata;
  logic [7:0]        io_rdata;
  logic              cfg_unlocked;
  logic [ND-1:0]     dev_active;
  logic [16*ND-1:0]  dev_base;

  always #5 clk = ~clk;

  cfg_port_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_unlocked(cfg_unlocked),
    .dev_active(dev_active), .dev_base(dev_base)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // reference model
  bit         m_unl;
  int         m_pos;
  logic [7:0] m_idx, m_ldn, m_last;
  bit         m_act  [ND];
  logic [15:0] m_base [ND];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] kb(input int p);
    return (p == 0) ? 8'h87 : (p == 1) ? 8'h01 : 8'h55;
  endfunction

  function automatic int bank_of(input logic [7:0] l);
    case (l)
      8'h07:   return 0;
      8'h09:   return 1;
      8'h0A:   return 2;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] m_reg();
    int b = bank_of(m_ldn);
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return 8'h87;
      8'h21: return 8'h12;
      8'h22: return 8'h08;
      8'h30: return (b >= 0) ? {7'b0, m_act[b]} : 8'h00;
      8'h60: return (b >= 0) ? m_base[b][15:8] : 8'h00;
      8'h61: return (b >= 0) ? m_base[b][7:0] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] m_read(input logic [15:0] a);
    if (a == IXA) return m_unl ? m_idx : 8'hFF;
    if (a == DTA) return m_unl ? m_reg() : 8'hFF;
    return m_last;
  endfunction

  task automatic m_write(input logic [15:0] a, input logic [7:0] d);
    int b = bank_of(m_ldn);
    if (a == IXA) begin
      if (!m_unl) begin
        if (d == kb(m_pos)) begin
          if (m_pos == 3) begin m_unl = 1; m_pos = 0; end
          else m_pos++;
        end else m_pos = (d == 8'h87) ? 1 : 0;
      end else m_idx = d;
    end else if (a == DTA && m_unl) begin
      case (m_idx)
        8'h02: if (d == 8'h02) begin m_unl = 0; m_idx = 8'h00; end
        8'h07: m_ldn = d;
        8'h30: if (b >= 0) m_act[b] = d[0];
        8'h60: if (b >= 0) m_base[b][15:8] = d;
        8'h61: if (b >= 0) m_base[b][7:0] = d;
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    m_write(a, d);
  endtask

  task automatic rd_chk(input logic [15:0] a, input string req);
    logic [7:0] e = m_read(a);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    chk(req, io_rdata, e);
    if (a == IXA || a == DTA) m_last = e;
  endtask

  task automatic rdwr_chk(input logic [15:0] a, input logic [7:0] d, input string req);
    logic [7:0] e = m_read(a);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_rd = 1'b1; io_wr = 1'b1;
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b0;
    chk(req, io_rdata, e);
    if (a == IXA || a == DTA) m_last = e;
    m_write(a, d);
  endtask

  task automatic outs_chk(input string req);
    for (int i = 0; i < ND; i++) begin
      chk({req, " active"}, dev_active[i], m_act[i]);
      chk({req, " base"}, dev_base[i*16 +: 16], m_base[i]);
    end
    chk({req, " unlocked"}, cfg_unlocked, m_unl);
  endtask

  task automatic unlock();
    wr(IXA, 8'h87); wr(IXA, 8'h01); wr(IXA, 8'h55); wr(IXA, 8'h55);
  endtask

  task automatic reg_wr(input logic [7:0] ix, input logic [7:0] d);
    wr(IXA, ix); wr(DTA, d);
  endtask

  initial begin
    #(10 * 100000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] pa [12];
    void'($urandom(32'd4242));
    m_unl = 0; m_pos = 0; m_idx = 0; m_ldn = 0; m_last = 0;
    for (int i = 0; i < ND; i++) begin m_act[i] = 0; m_base[i] = 0; end
    io_addr = '0; io_wr = 0; io_rd = 0; io_wdata = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rdata", io_rdata, 8'h00);
    outs_chk("R1");

    // R2 sealed behaviour
    wr(DTA, 8'h01);
    rd_chk(DTA, "R2 sealed data read");
    rd_chk(IXA, "R2 sealed index read");
    outs_chk("R2");

    // R4 broken key then restart; 0x87 as breaker counts as first byte
    wr(IXA, 8'h87); wr(IXA, 8'h01); wr(IXA, 8'h99); wr(IXA, 8'h55); wr(IXA, 8'h55);
    chk("R4 broken key stays sealed", cfg_unlocked, 1'b0);
    wr(IXA, 8'h87); wr(IXA, 8'h87); wr(IXA, 8'h01); wr(IXA, 8'h55); wr(IXA, 8'h55);
    chk("R4 repeated first byte opens", cfg_unlocked, 1'b1);
    rd_chk(IXA, "R3 index read after open");

    // R6 identifier and revision, writes discarded
    reg_wr(8'h20, 8'h00);
    rd_chk(DTA, "R6 id high");
    wr(IXA, 8'h21); rd_chk(DTA, "R6 id low");
    wr(IXA, 8'h22); rd_chk(DTA, "R6 revision");

    // R7/R8/R9 banks
    reg_wr(8'h07, 8'h07); rd_chk(DTA, "R7 selector read");
    reg_wr(8'h30, 8'hFE); rd_chk(DTA, "R8 enable bit0 only");
    reg_wr(8'h30, 8'hFF); rd_chk(DTA, "R8 enable readback");
    reg_wr(8'h60, 8'h12); reg_wr(8'h61, 8'h34);
    rd_chk(DTA, "R9 base low");
    wr(IXA, 8'h07); wr(DTA, 8'h0A);
    reg_wr(8'h60, 8'h02); reg_wr(8'h61, 8'h08);
    outs_chk("R9 banks");
    wr(IXA, 8'h07); wr(DTA, 8'h09);
    wr(IXA, 8'h60); rd_chk(DTA, "R7 bank1 separate");

    // R10 unmatched selector and unimplemented index
    reg_wr(8'h07, 8'h05);
    reg_wr(8'h30, 8'h01); rd_chk(DTA, "R10 unmatched bank read");
    outs_chk("R10");
    reg_wr(8'h40, 8'h5A); rd_chk(DTA, "R10 unimplemented index");

    // R11 same-cycle read and write on the data port
    reg_wr(8'h07, 8'h07);
    wr(IXA, 8'h61);
    rdwr_chk(DTA, 8'hC3, "R11 read sees old base");
    rd_chk(DTA, "R11 write took effect");
    wr(IXA, 8'h07);
    rdwr_chk(DTA, 8'h09, "R11 selector old value");

    // R12 foreign address
    wr(16'h0080, 8'h02);
    rd_chk(16'h0080, "R12 foreign read holds");
    outs_chk("R12");

    // R5 exit
    reg_wr(8'h02, 8'h03);
    chk("R5 wrong exit value", cfg_unlocked, 1'b1);
    wr(DTA, 8'h02);
    chk("R5 exit seals", cfg_unlocked, 1'b0);
    rd_chk(DTA, "R5 sealed after exit");
    unlock();
    rd_chk(IXA, "R5 index cleared by exit");
    wr(IXA, 8'h02);
    rdwr_chk(DTA, 8'h02, "R11 exit same-cycle read");
    chk("R5 exit with read", cfg_unlocked, 1'b0);

    // random phase
    pa = '{16'h002E, 16'h002E, 16'h002E, 16'h002F, 16'h002F, 16'h002F,
           16'h002F, 16'h002E, 16'h002F, 16'h0030, 16'h002D, 16'h002F};
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      int          op;
      int          k;
      a  = pa[$urandom_range(0, 11)];
      k  = $urandom_range(0, 11);
      case (k)
        0: d = 8'h87; 1: d = 8'h01; 2, 3: d = 8'h55; 4: d = 8'h02;
        5: d = 8'h07; 6: d = 8'h09; 7: d = 8'h0A; 8: d = 8'h30;
        9: d = 8'h60; 10: d = 8'h61;
        default: d = 8'($urandom);
      endcase
      op = $urandom_range(0, 9);
      if (op < 5) wr(a, d);
      else if (op < 9) rd_chk(a, "R11 random read");
      else rdwr_chk(a, d, "R11 random read with write");
      if (n % 20 == 0) outs_chk("R9 random outputs");
    end
    outs_chk("R8 final outputs");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule